// File: doc/BRIEF.md
# Rotating-Priority Shared Bus Arbiter

This block decides, once per clock, which of `N` requesters may drive a single shared bus. Its decision is held in a register, so a request seen at one clock edge shows up as a one-hot grant after that edge. The grant logic does not ripple from one position to the next. The block rotates the request vector so that the current start position sits at bit zero. A log-depth prefix-OR network then tells each position whether some earlier position in chain order has already claimed the bus. A position wins when it requests and nothing ahead of it does. The result is rotated back to the original positions.

Fairness comes from the start position. After every new grant it moves to the slot just past the winner, so a requester that has just won drops to the lowest priority, and the order wraps from the last index back to index zero. A requester that needs several cycles raises `lock_i` while it owns the bus. This freezes both the grant and the start position until `lock_i` falls.

Top module: `rr_prefix_arbiter`

## Requirements
- R1: After reset the grant vector is all zeros, `gnt_valid_o` is low, and requester 0 holds the highest priority.
- R2: A grant appears one cycle after the request that caused it. It is only ever given to a requester whose `req_i` bit was high at the deciding edge.
- R3: `gnt_o` is always one-hot or all zeros.
- R4: When not holding, the winner is the first requesting index found by scanning upward from the start position and wrapping from N-1 to 0.
- R5: Each new grant to index k moves the start position to (k+1) mod N. A cycle with no grant leaves the start position unchanged.
- R6: If `lock_i` is high while a grant is active, the next cycle keeps the same grant and the same start position, whatever `req_i` is. If `lock_i` is high with no active grant, it has no effect and arbitration proceeds as normal.
- R7: With `req_i` all zeros and no hold in force, the next cycle shows an all-zero grant and low `gnt_valid_o`.
- R8: `gnt_valid_o` is high exactly when some bit of `gnt_o` is high. N must be a power of two no smaller than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N | One request bit per requester |
| lock_i | input | 1 | Keeps the present grant for another cycle |
| gnt_o | output | N | Registered one-hot grant |
| gnt_valid_o | output | 1 | Some requester holds the bus |

## Verification
The hardest thing to set up from the ports is a chosen start position paired with a chosen request pattern, because the start position is internal and changes after every grant. The bench first issues a single request from the slot just before the target position, which leaves the start position where it is wanted. It then applies every request pattern from that position, for each of the four positions of an N=4 instance. It tests the hold behaviour the same way, by locking after a known grant, and it also locks with no grant active to confirm that nothing is held.

// File: rtl/rr_prefix_arbiter.sv
module rr_prefix_arbiter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         lock_i,
  output logic [N-1:0] gnt_o,
  output logic         gnt_valid_o
);
  localparam int LG = $clog2(N);

  initial begin
    if (N < 2 || (1 << LG) != N) $error("N must be a power of two, at least 2");
  end

  logic [LG-1:0]  ptr_q;
  logic [N-1:0]   gnt_q;
  logic [2*N-1:0] rot_wide, back_wide;
  logic [N-1:0]   rot_req, avail, won_rot, gnt_next;
  logic [N-1:0]   pf [LG+1];
  logic [LG-1:0]  win_idx;
  logic           hold;

  assign rot_wide = {req_i, req_i} >> ptr_q;
  assign rot_req  = rot_wide[N-1:0];
  assign pf[0]    = rot_req;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= (1 << k)) begin : g_merge
        assign pf[k+1][i] = pf[k][i] | pf[k][i-(1<<k)];
      end else begin : g_pass
        assign pf[k+1][i] = pf[k][i];
      end
    end
  end

  assign avail     = ~{pf[LG][N-2:0], 1'b0};
  assign won_rot   = rot_req & avail;
  assign back_wide = {won_rot, won_rot} << ptr_q;
  assign gnt_next  = back_wide[2*N-1:N];

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt_next[i]) win_idx = win_idx | LG'(i);
  end

  assign hold = lock_i & (|gnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else if (!hold) begin
      gnt_q <= gnt_next;
      if (|gnt_next) ptr_q <= win_idx + LG'(1);
    end
  end

  assign gnt_o       = gnt_q;
  assign gnt_valid_o = |gnt_q;

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));

  a_r2_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> ((gnt_o & ~$past(req_i)) == '0));

  a_r6_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(gnt_o) && $stable(ptr_q)));

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && req_i == '0) |=> !gnt_valid_o);

  a_r5_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && req_i != '0) |=> gnt_o[ptr_q - LG'(1)]);
endmodule

// File: tb/sim_rr_prefix_arbiter.sv
`timescale 1ns/1ps
module sim_rr_prefix_arbiter;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, lock = 0;
  logic [N-1:0] req = '0, gnt;
  logic gv;
  int total = 0, bad = 0;
  int m_ptr = 0;
  logic [N-1:0] m_gnt = '0;

  always #2 clk = ~clk;

  rr_prefix_arbiter #(.N(N)) u0 (.clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock),
    .gnt_o(gnt), .gnt_valid_o(gv));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model(input logic [N-1:0] r, input logic l);
    if (l && m_gnt != '0) return;
    m_gnt = '0;
    for (int j = 0; j < N; j++) begin
      int idx;
      idx = (m_ptr + j) % N;
      if (r[idx]) begin
        m_gnt = N'(1) << idx;
        m_ptr = (idx + 1) % N;
        return;
      end
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic l, input string tag);
    @(negedge clk);
    req = r; lock = l;
    model(r, l);
    @(posedge clk); #1;
    chk(tag, gnt, m_gnt);
    chk("R8 valid", {{(N-1){1'b0}}, gv}, {{(N-1){1'b0}}, |m_gnt});
  endtask

  initial begin
    #1;
    chk("R1 reset grant", gnt, '0);
    chk("R1 reset valid", {{(N-1){1'b0}}, gv}, '0);
    #10 rst_n = 1;
    step('1, 0, "R1 start at zero");
    for (int p = 0; p < N; p++)
      for (int r = 0; r < (1 << N); r++) begin
        step(N'(1) << ((p + N - 1) % N), 0, "R5 pointer setup");
        step(N'(r), 0, (r == 0) ? "R7 idle" : "R4 cyclic winner");
      end
    for (int r = 0; r < (1 << N); r++) begin
      step(N'(r) | 4'b0100, 0, "R2 grant");
      step(N'(r), 1, "R6 lock holds");
      step(~N'(r), 1, "R6 lock holds");
      step(N'(r), 0, "R5 after unlock");
    end
    for (int r = 0; r < (1 << N); r++) begin
      step('0, 0, "R7 idle");
      step(N'(r), 1, "R6 lock without grant");
      chk("R3 onehot", N'($countones(gnt) > 1), '0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule